// File: doc/BRIEF.md
# Dual-Phase Serial Frame Transmitter

This block turns a stream of parallel data words into a serial bit stream on one data line. Frames are started by an external frame-sync strobe, and every step of the block is paced by a one-cycle bit-clock enable (the bit tick). A frame has a first phase and an optional second phase. Each phase has its own number of elements and its own element size in bits. Each element carries one data word, taken through a valid/ready handshake. The word is right-aligned: only its low element-size bits go out.

The configuration word is captured when the frame-sync tick starts a frame. It sets:
- the element codes for each phase;
- a data delay of 0 to 3 ticks before the first bit;
- the bit order;
- whether a second phase exists, and whether that phase follows at once or waits for another sync;
- what happens when a sync arrives in the middle of a frame: the frame is aborted with an error flag, or the sync is ignored.

The state machine has four states:
- IDLE: waiting for a frame sync.
- DELAY: counting out the data delay.
- SHIFT: sending element bits.
- GAP: phase 1 is done and the second phase waits for its own sync.

Its transitions are:
- start: IDLE to DELAY when the delay is not zero, or IDLE to SHIFT when it is zero.
- delay-done: DELAY to SHIFT.
- next-element: SHIFT to SHIFT.
- phase-chain: SHIFT to SHIFT, into phase 2 with no gap.
- phase-park: SHIFT to GAP.
- resume: GAP to DELAY or SHIFT.
- finish: SHIFT to IDLE.
- abort: DELAY or SHIFT to IDLE.

Top module: `serial_frame_tx`

## Requirements
- R1: After reset, sdata, busy, underrun, fs_err and data_ready are all 0.
- R2: A tick with fsync high in IDLE starts a frame, and busy is 1 after that tick. With data delay D = cfg[14:13], the first data bit appears on sdata after the tick that comes D ticks after the sync tick. Later bits follow one per tick. sdata is 0 before the first data bit.
- R3: The element size code is cfg[2:0] for phase 1 and cfg[18:16] for phase 2. Codes 0 to 7 give 8, 10, 12, 14, 16, 20, 24 and 32 bits. Only the low bits of each word, up to that size, are sent.
- R4: The element count is cfg[9:3] for phase 1 and cfg[25:19] for phase 2. The field holds the count minus one, so code 0 means one element and code 11 means twelve.
- R5: cfg[12]=0 sends the most significant bit of each element first. cfg[12]=1 sends the least significant bit first.
- R6: cfg[27]=1 adds phase 2. With cfg[26]=0, the first bit of phase 2 comes on the tick right after the last bit of phase 1.
- R7: With cfg[27]=1 and cfg[26]=1, the block waits after phase 1 with sdata 0 and busy 1. A later fsync tick starts phase 2 after the same data delay D.
- R8: busy stays 1 until the tick after the last bit of the final phase. On that tick busy and sdata return to 0.
- R9: If data_valid is 0 when an element starts, that element is sent as zeros. underrun is then set and stays set until reset.
- R10: With cfg[15]=0, an fsync tick in DELAY or SHIFT ends the frame at that tick: busy and sdata go to 0. fs_err is then set and stays set until reset. Such a tick includes the tick that would end the frame. A later frame then runs normally.
- R11: With cfg[15]=1, an fsync tick in the middle of a frame has no effect on sdata, busy or fs_err.
- R12: data_ready is 1 only during the tick on which an element starts, and there is exactly one such tick per element. sdata and busy change only after a tick.
- R13: The configuration is taken at the frame-start tick. Changes to cfg during a frame do not affect that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg | input | CFG_W | Frame configuration word |
| bit_en | input | 1 | Bit tick, one cycle per bit period |
| fsync | input | 1 | Frame sync, sampled on bit ticks |
| data_in | input | DATA_W | Word for the next element, right-aligned |
| data_valid | input | 1 | data_in holds a word |
| data_ready | output | 1 | An element starts this cycle; the word is taken if valid |
| sdata | output | 1 | Serial data line |
| busy | output | 1 | Frame in progress |
| underrun | output | 1 | Sticky: an element started with no word available |
| fs_err | output | 1 | Sticky: a frame was aborted by a mid-frame sync |

## Verification
The assertions check the following on every cycle:
- the flags stay sticky;
- an underrun is flagged right after a start with no word available;
- data_ready appears only on ticks;
- sdata and busy hold between ticks;
- an abort sync empties the frame and flags the error on the next cycle;
- the bit pointer stays inside the element.

Only the bench scenarios can show these:
- bit order;
- the exact tick of each data bit across all delays, element sizes and phase layouts;
- how many words a frame consumes;
- that an ignored sync or a cfg change during a frame leaves the stream intact.

// File: rtl/sft_pkg.sv
`timescale 1ns/1ps
package sft_pkg;
    localparam int LEN_W = 6;   // holds element sizes up to 32
    localparam int CNT_W = 7;   // element count code width

    // field positions inside the configuration word
    localparam int F_LEN1   = 0;
    localparam int F_CNT1   = 3;
    localparam int F_ORDER  = 12;
    localparam int F_DELAY  = 13;
    localparam int F_FSIGN  = 15;
    localparam int F_LEN2   = 16;
    localparam int F_CNT2   = 19;
    localparam int F_P2SYNC = 26;
    localparam int F_DUAL   = 27;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DELAY = 2'd1,
        ST_SHIFT = 2'd2,
        ST_GAP   = 2'd3
    } sft_state_e;

    typedef struct packed {
        logic [LEN_W-1:0] len1;
        logic [LEN_W-1:0] len2;
        logic [CNT_W-1:0] cnt1;
        logic [CNT_W-1:0] cnt2;
        logic [1:0]       ddly;
        logic             lsb_first;
        logic             fs_ignore;
        logic             dual;
        logic             p2_on_sync;
    } sft_fields_t;

    function automatic logic [LEN_W-1:0] elem_bits(input logic [2:0] code);
        logic [LEN_W-1:0] r;
        unique case (code)
            3'd0: r = 6'd8;
            3'd1: r = 6'd10;
            3'd2: r = 6'd12;
            3'd3: r = 6'd14;
            3'd4: r = 6'd16;
            3'd5: r = 6'd20;
            3'd6: r = 6'd24;
            default: r = 6'd32;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/sft_cfg_decode.sv
`timescale 1ns/1ps
module sft_cfg_decode
    import sft_pkg::*;
#(
    parameter int CFG_W = 32
) (
    input  logic [CFG_W-1:0] cfg,
    output sft_fields_t      fld
);
    logic unused_bits;
    assign unused_bits = ^{cfg[11:10], cfg[CFG_W-1:28]};

    always_comb begin
        fld.len1       = elem_bits(cfg[F_LEN1 +: 3]);
        fld.len2       = elem_bits(cfg[F_LEN2 +: 3]);
        fld.cnt1       = cfg[F_CNT1 +: CNT_W];
        fld.cnt2       = cfg[F_CNT2 +: CNT_W];
        fld.ddly       = cfg[F_DELAY +: 2];
        fld.lsb_first  = cfg[F_ORDER];
        fld.fs_ignore  = cfg[F_FSIGN];
        fld.dual       = cfg[F_DUAL];
        fld.p2_on_sync = cfg[F_P2SYNC];
    end
endmodule

// File: rtl/sft_shift.sv
`timescale 1ns/1ps
module sft_shift #(
    parameter int DATA_W = 32,
    parameter int LEN_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              adv,
    input  logic [DATA_W-1:0] word_in,
    input  logic [LEN_W-1:0]  len_in,
    input  logic              lsb_first,
    output logic              bit_out,
    output logic              last_bit
);
    localparam int IDX_W = $clog2(DATA_W);

    logic [DATA_W-1:0] word_q;
    logic [LEN_W-1:0]  len_q;
    logic [LEN_W-1:0]  k_q;
    logic [LEN_W-1:0]  pos;
    logic              unused_pos;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
            len_q  <= LEN_W'(8);
            k_q    <= '0;
        end else if (load) begin
            word_q <= word_in;
            len_q  <= len_in;
            k_q    <= '0;
        end else if (adv) begin
            k_q    <= k_q + 1'b1;
        end
    end

    assign pos        = lsb_first ? k_q : (len_q - 1'b1 - k_q);
    assign unused_pos = ^pos[LEN_W-1:IDX_W];
    assign bit_out    = word_q[pos[IDX_W-1:0]];
    assign last_bit   = (k_q == len_q - 1'b1);

    AST_POS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        k_q < len_q);                                                   // R3
endmodule

// File: rtl/serial_frame_tx.sv
`timescale 1ns/1ps
module serial_frame_tx
    import sft_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CFG_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CFG_W-1:0]  cfg,
    input  logic              bit_en,
    input  logic              fsync,
    input  logic [DATA_W-1:0] data_in,
    input  logic              data_valid,
    output logic              data_ready,
    output logic              sdata,
    output logic              busy,
    output logic              underrun,
    output logic              fs_err
);
    sft_state_e  state_q, state_d;
    sft_fields_t fld_live, fld_q, fsel;
    logic        p2_q;
    logic [CNT_W-1:0] elem_q;
    logic [1:0]  dly_q;
    logic        underrun_q, fs_err_q;

    logic start_elem, adv, load_cnt, dec_cnt, dly_load, dly_dec;
    logic p2_set, p2_clr, latch_cfg, abort, use_p2;
    logic mid_fs, bit_val, last_bit;
    logic [LEN_W-1:0] len_sel;
    logic [CNT_W-1:0] cnt_sel;

    sft_cfg_decode #(.CFG_W(CFG_W)) u_dec (
        .cfg (cfg),
        .fld (fld_live)
    );

    assign fsel   = (state_q == ST_IDLE) ? fld_live : fld_q;
    assign mid_fs = bit_en && fsync && !fsel.fs_ignore;

    // next state and control
    always_comb begin
        state_d    = state_q;
        start_elem = 1'b0;
        adv        = 1'b0;
        load_cnt   = 1'b0;
        dec_cnt    = 1'b0;
        dly_load   = 1'b0;
        dly_dec    = 1'b0;
        p2_set     = 1'b0;
        p2_clr     = 1'b0;
        latch_cfg  = 1'b0;
        abort      = 1'b0;
        use_p2     = p2_q;
        unique case (state_q)
            ST_IDLE: begin
                use_p2 = 1'b0;
                if (bit_en && fsync) begin                 // start
                    latch_cfg = 1'b1;
                    p2_clr    = 1'b1;
                    load_cnt  = 1'b1;
                    if (fsel.ddly == 2'd0) begin
                        start_elem = 1'b1;
                        state_d    = ST_SHIFT;
                    end else begin
                        dly_load = 1'b1;
                        state_d  = ST_DELAY;
                    end
                end
            end
            ST_DELAY: begin
                if (mid_fs) begin                          // abort
                    abort   = 1'b1;
                    state_d = ST_IDLE;
                end else if (bit_en) begin
                    if (dly_q == 2'd0) begin               // delay-done
                        start_elem = 1'b1;
                        state_d    = ST_SHIFT;
                    end else begin
                        dly_dec = 1'b1;
                    end
                end
            end
            ST_SHIFT: begin
                if (mid_fs) begin                          // abort
                    abort   = 1'b1;
                    state_d = ST_IDLE;
                end else if (bit_en) begin
                    if (!last_bit) begin
                        adv = 1'b1;
                    end else if (elem_q != '0) begin       // next-element
                        start_elem = 1'b1;
                        dec_cnt    = 1'b1;
                    end else if (!p2_q && fsel.dual) begin
                        p2_set = 1'b1;
                        if (fsel.p2_on_sync) begin         // phase-park
                            state_d = ST_GAP;
                        end else begin                     // phase-chain
                            use_p2     = 1'b1;
                            load_cnt   = 1'b1;
                            start_elem = 1'b1;
                        end
                    end else begin                         // finish
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_GAP: begin
                use_p2 = 1'b1;
                if (bit_en && fsync) begin                 // resume
                    load_cnt = 1'b1;
                    if (fsel.ddly == 2'd0) begin
                        start_elem = 1'b1;
                        state_d    = ST_SHIFT;
                    end else begin
                        dly_load = 1'b1;
                        state_d  = ST_DELAY;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign len_sel = use_p2 ? fsel.len2 : fsel.len1;
    assign cnt_sel = use_p2 ? fsel.cnt2 : fsel.cnt1;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // frame bookkeeping registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fld_q      <= '0;
            p2_q       <= 1'b0;
            elem_q     <= '0;
            dly_q      <= '0;
            underrun_q <= 1'b0;
            fs_err_q   <= 1'b0;
        end else begin
            if (latch_cfg) fld_q <= fld_live;
            if (p2_clr)      p2_q <= 1'b0;
            else if (p2_set) p2_q <= 1'b1;
            if (load_cnt)     elem_q <= cnt_sel;
            else if (dec_cnt) elem_q <= elem_q - 1'b1;
            if (dly_load)     dly_q <= fsel.ddly - 2'd1;
            else if (dly_dec) dly_q <= dly_q - 2'd1;
            if (start_elem && !data_valid) underrun_q <= 1'b1;
            if (abort) fs_err_q <= 1'b1;
        end
    end

    sft_shift #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (start_elem),
        .adv       (adv),
        .word_in   (data_valid ? data_in : '0),
        .len_in    (len_sel),
        .lsb_first (fsel.lsb_first),
        .bit_out   (bit_val),
        .last_bit  (last_bit)
    );

    // outputs
    always_comb begin
        sdata      = (state_q == ST_SHIFT) && bit_val;
        busy       = (state_q != ST_IDLE);
        data_ready = start_elem;
        underrun   = underrun_q;
        fs_err     = fs_err_q;
    end

    AST_READY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        data_ready |-> bit_en);                                          // R12
    AST_HOLD_OFF_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> ($stable(sdata) && $stable(busy)));                  // R12
    AST_UNDERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (data_ready && !data_valid) |=> underrun);                       // R9
    AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> underrun);                                          // R9
    AST_FSERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        fs_err |=> fs_err);                                              // R10
    AST_ABORT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && fsync && !fld_q.fs_ignore &&
         (state_q == ST_DELAY || state_q == ST_SHIFT)) |=> (!busy && fs_err)); // R10
endmodule

// File: tb/tb_serial_frame_tx.sv
`timescale 1ns/1ps
module tb_serial_frame_tx;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] cfg;
    logic        bit_en, fsync;
    logic [31:0] data_in;
    logic        data_valid;
    logic        data_ready, sdata, busy, underrun, fs_err;

    int checks = 0;
    int fails  = 0;
    int widx   = 0;

    always #5 clk = ~clk;

    serial_frame_tx #(.DATA_W(32), .CFG_W(32)) dut (
        .clk(clk), .rst_n(rst_n), .cfg(cfg), .bit_en(bit_en), .fsync(fsync),
        .data_in(data_in), .data_valid(data_valid), .data_ready(data_ready),
        .sdata(sdata), .busy(busy), .underrun(underrun), .fs_err(fs_err)
    );

    function automatic logic [31:0] word_of(input int i);
        return 32'hC3A5_96E1 ^ (32'(i) * 32'h0101_0F07) ^ (32'(i) << 19);
    endfunction

    function automatic int len_of(input logic [2:0] c);
        case (c)
            3'd0: return 8;
            3'd1: return 10;
            3'd2: return 12;
            3'd3: return 14;
            3'd4: return 16;
            3'd5: return 20;
            3'd6: return 24;
            default: return 32;
        endcase
    endfunction

    function automatic logic [31:0] mk_cfg(input logic [2:0] l1, input logic [6:0] c1,
                                           input logic [2:0] l2, input logic [6:0] c2,
                                           input logic [1:0] d, input logic lsb,
                                           input logic ign, input logic dual, input logic wt);
        logic [31:0] c = '0;
        c[2:0] = l1; c[9:3] = c1; c[18:16] = l2; c[25:19] = c2;
        c[14:13] = d; c[12] = lsb; c[15] = ign; c[27] = dual; c[26] = wt;
        return c;
    endfunction

    task automatic check_bit(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    task automatic check_int(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick(input logic fs, output logic rdy, output logic sd, output logic bz);
        @(negedge clk);
        bit_en = 1'b1;
        fsync  = fs;
        #1 rdy = data_ready;
        @(posedge clk);
        #1;
        sd = sdata;
        bz = busy;
        if (rdy && data_valid) begin
            widx++;
            data_in = word_of(widx);
        end
        @(negedge clk);
        bit_en = 1'b0;
        fsync  = 1'b0;
    endtask

    // runs one frame and compares every tick against a model built from the requirements
    task automatic run_frame(input string req, input logic [31:0] c, input logic [31:0] c_after,
                             input int gap_fs, input int mid_fs, input logic valid);
        logic exp_sd [0:1023];
        int d, l1, n1, l2, n2, st, endt, limit, nel, rdy_cnt, base, e, t;
        logic lsb, dual, wt, ign, rdy, sd, bz;
        logic [31:0] w;
        d = int'(c[14:13]); lsb = c[12]; ign = c[15]; dual = c[27]; wt = c[26];
        l1 = len_of(c[2:0]);   n1 = int'(c[9:3]) + 1;
        l2 = len_of(c[18:16]); n2 = int'(c[25:19]) + 1;
        data_valid = valid;
        base = widx;
        limit = (mid_fs >= 0 && !ign) ? mid_fs : 100000;
        for (int i = 0; i < 1024; i++) exp_sd[i] = 1'b0;
        st = d; e = 0; nel = 0;
        for (int ph = 0; ph < 2; ph++) begin
            int len, cnt;
            if (ph == 1 && !dual) break;
            len = (ph == 0) ? l1 : l2;
            cnt = (ph == 0) ? n1 : n2;
            if (ph == 1 && wt) st = gap_fs + d;
            for (int i = 0; i < cnt; i++) begin
                w = word_of(base + e);
                if (st < limit) nel++;
                for (int k = 0; k < len; k++) begin
                    if (st + k < limit && st + k < 1024)
                        exp_sd[st + k] = valid ? (lsb ? w[k] : w[len - 1 - k]) : 1'b0;
                end
                st += len;
                e++;
            end
        end
        endt = st;
        rdy_cnt = 0;
        cfg = c;
        for (t = 0; t < endt + 3 && t < 1024; t++) begin
            tick((t == 0) || (t == gap_fs) || (t == mid_fs), rdy, sd, bz);
            if (t == 0) cfg = c_after;
            if (rdy) rdy_cnt++;
            check_bit(req, $sformatf("sdata tick %0d", t), sd, exp_sd[t]);
            check_bit(req, $sformatf("busy tick %0d", t), bz, (t < endt) && (t < limit));
        end
        check_int({req, " R12"}, "element starts", rdy_cnt, nel);
        data_valid = 1'b1;
    endtask

    initial begin
        #1_900_000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] c;
        rst_n = 1'b0; bit_en = 1'b0; fsync = 1'b0; cfg = '0;
        data_valid = 1'b1; data_in = word_of(0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check_bit("R1", "sdata", sdata, 1'b0);
        check_bit("R1", "busy", busy, 1'b0);
        check_bit("R1", "underrun", underrun, 1'b0);
        check_bit("R1", "fs_err", fs_err, 1'b0);
        check_bit("R1", "data_ready", data_ready, 1'b0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // sweep of size codes, bit order and data delay: R2 R3 R4 R5 R8
        for (int lc = 0; lc < 8; lc++)
            for (int o = 0; o < 2; o++)
                for (int d = 0; d < 4; d++) begin
                    c = mk_cfg(3'(lc), 7'd1, 3'd0, 7'd0, 2'(d), 1'(o), 1'b1, 1'b0, 1'b0);
                    run_frame("R2 R3 R4 R5 R8", c, c, -1, -1, 1'b1);
                end

        // R6 R4: one 16-bit element then twelve 20-bit elements, chained, delay 1
        c = mk_cfg(3'd4, 7'd0, 3'd5, 7'd11, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0);
        run_frame("R6 R4", c, c, -1, -1, 1'b1);

        // R7: phase 2 waits for its own sync, delay 2; phase 1 ends at tick 18
        c = mk_cfg(3'd0, 7'd1, 3'd1, 7'd2, 2'd2, 1'b0, 1'b1, 1'b1, 1'b1);
        run_frame("R7", c, c, 22, -1, 1'b1);
        c = mk_cfg(3'd2, 7'd0, 3'd7, 7'd1, 2'd0, 1'b1, 1'b1, 1'b1, 1'b1);
        run_frame("R7 R5", c, c, 15, -1, 1'b1);

        // R11: mid-frame sync ignored
        c = mk_cfg(3'd4, 7'd1, 3'd0, 7'd0, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0);
        run_frame("R11", c, c, -1, 10, 1'b1);
        check_bit("R11", "fs_err after ignored sync", fs_err, 1'b0);

        // R13: cfg changed right after the start tick
        c = mk_cfg(3'd4, 7'd0, 3'd0, 7'd0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0);
        run_frame("R13", c, mk_cfg(3'd7, 7'd3, 3'd7, 7'd3, 2'd3, 1'b1, 1'b0, 1'b1, 1'b1),
                  -1, -1, 1'b1);

        // R9: underrun
        check_bit("R9", "underrun before starvation", underrun, 1'b0);
        c = mk_cfg(3'd2, 7'd1, 3'd0, 7'd0, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0);
        run_frame("R9", c, c, -1, -1, 1'b0);
        check_bit("R9", "underrun set", underrun, 1'b1);
        run_frame("R9", c, c, -1, -1, 1'b1);
        check_bit("R9", "underrun sticky", underrun, 1'b1);

        // R10: abort while shifting, then while delaying, then a normal frame
        check_bit("R10", "fs_err before abort", fs_err, 1'b0);
        c = mk_cfg(3'd4, 7'd1, 3'd0, 7'd0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0);
        run_frame("R10", c, c, -1, 9, 1'b1);
        check_bit("R10", "fs_err set", fs_err, 1'b1);
        c = mk_cfg(3'd0, 7'd0, 3'd0, 7'd0, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0);
        run_frame("R10", c, c, -1, 2, 1'b1);
        // sync on the tick that would end the frame: 8 bits at ticks 0..7, end tick 8
        c = mk_cfg(3'd0, 7'd0, 3'd0, 7'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        run_frame("R10", c, c, -1, 8, 1'b1);
        c = mk_cfg(3'd3, 7'd2, 3'd0, 7'd0, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0);
        run_frame("R10", c, c, -1, -1, 1'b1);
        check_bit("R10", "fs_err sticky", fs_err, 1'b1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule